// File: doc/BRIEF.md
# Monotonic Capability Manipulation Unit

This unit applies one of four guarded modifications to a fat-pointer capability: narrowing its bounds, clearing permission bits, replacing its offset, or adding to its offset. A capability is presented as a tag, a sealed flag, a permission field, a base, a length and a base-relative offset. Each request also carries one operand. The unit returns the modified capability together with an exception flag and a cause code. It enforces every rule that lets authority only shrink. A derivation that would widen rights, or that starts from an untagged or sealed source, is refused.

The datapath is combinational and feeds one output register. A two-state controller tracks whether that register holds a fresh result. Its states are ST_IDLE (no result pending) and ST_RESULT (a result is presented for one cycle). It has three transitions. ACCEPT goes from ST_IDLE to ST_RESULT when `in_valid` is high. STREAM stays in ST_RESULT when `in_valid` is high again. DRAIN goes from ST_RESULT to ST_IDLE when `in_valid` is low.

When a request faults, the output is the source capability unchanged. A two-bit cause names the first check that failed.

Top module: `cap_monotonic_unit`

## Requirements
- R1: Every cycle with `in_valid` high yields `out_valid` high on the following cycle. A cycle with `in_valid` low yields `out_valid` low on the following cycle. During reset `out_valid`, `out_exc` and `out_tag` are 0.
- R2: Opcode 2'b00 (narrow bounds) produces base = in_base + in_off, length = in_operand and offset = 0. Permissions are unchanged.
- R3: Narrow bounds raises an exception with cause 2'b11 when in_base + in_off + in_operand exceeds in_base + in_len. Both sums are computed without wrap. A new range that ends exactly at the old top is accepted.
- R4: Opcode 2'b01 (mask permissions) produces perms = in_perms AND in_operand[PW-1:0]. Base, length and offset are unchanged.
- R5: Opcode 2'b10 (replace offset) produces offset = in_operand. It raises no exception, even when the pointer lands outside its bounds.
- R6: Opcode 2'b11 (advance offset) produces offset = (in_off + in_operand) mod 2^AW. It never raises an exception.
- R7: An input with tag 0 raises an exception with cause 2'b01 for every opcode, and `out_tag` is 0.
- R8: A tagged input with the sealed flag set raises an exception with cause 2'b10 for every opcode.
- R9: When an exception is raised, every output capability field equals the input. The cause priority is tag first, then seal, then bounds.
- R10: A request without a fault returns tag 1, sealed 0 and cause 2'b00, with `out_exc` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation select |
| in_tag | input | 1 | Source validity tag |
| in_sealed | input | 1 | Source sealed flag |
| in_perms | input | PW | Source permission bits |
| in_base | input | AW | Source base address |
| in_len | input | AW | Source length |
| in_off | input | AW | Source offset from base |
| in_operand | input | AW | Operand: new length, mask, offset or increment |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | 1 | Result tag |
| out_sealed | output | 1 | Result sealed flag |
| out_perms | output | PW | Result permissions |
| out_base | output | AW | Result base |
| out_len | output | AW | Result length |
| out_off | output | AW | Result offset |
| out_exc | output | 1 | Exception raised |
| out_cause | output | 2 | 0 none, 1 tag, 2 seal, 3 bounds |

## Verification
The bench probes the top edge of the old range with a request that ends exactly at it and another that overshoots it by one byte. A comparison off by one would either reject the exact fit or accept the overshoot. It also narrows with an offset already past the top, which a check of the length alone would wrongly accept. It advances an offset across the top of the address space and moves an offset far outside bounds; a design that trapped on out-of-bounds pointers would fault there. An input that is both untagged and sealed, and faulty in its bounds, exposes a wrong cause priority or a tag that leaks onto the result.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

    typedef enum logic [1:0] {
        OP_NARROW  = 2'b00,
        OP_MASK    = 2'b01,
        OP_SETOFF  = 2'b10,
        OP_ADVOFF  = 2'b11
    } cmu_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_TAG    = 2'b01,
        CAUSE_SEAL   = 2'b10,
        CAUSE_BOUNDS = 2'b11
    } cmu_cause_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } cmu_state_e;

endpackage

// File: rtl/cmu_bounds.sv
module cmu_bounds #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] off_i,
    input  logic [AW-1:0] req_len_i,
    output logic [AW-1:0] new_base_o,
    output logic          viol_o
);
    localparam int WW = AW + 2;

    logic [WW-1:0] old_top;
    logic [WW-1:0] new_lo;
    logic [WW-1:0] new_top;

    always_comb begin
        old_top    = {2'b00, base_i} + {2'b00, len_i};
        new_lo     = {2'b00, base_i} + {2'b00, off_i};
        new_top    = new_lo + {2'b00, req_len_i};
        viol_o     = (new_top > old_top);
        new_base_o = new_lo[AW-1:0];
    end
endmodule

// File: rtl/cmu_offset_alu.sv
module cmu_offset_alu #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] off_i,
    input  logic [AW-1:0] operand_i,
    input  logic          advance_i,
    output logic [AW-1:0] off_o
);
    always_comb begin
        if (advance_i) off_o = off_i + operand_i;
        else           off_o = operand_i;
    end
endmodule

// File: rtl/cmu_fault_sel.sv
module cmu_fault_sel
    import cmu_pkg::*;
(
    input  logic       tag_i,
    input  logic       sealed_i,
    input  logic       bounds_en_i,
    input  logic       bounds_viol_i,
    output cmu_cause_e cause_o
);
    always_comb begin
        if (!tag_i)                            cause_o = CAUSE_TAG;
        else if (sealed_i)                     cause_o = CAUSE_SEAL;
        else if (bounds_en_i && bounds_viol_i) cause_o = CAUSE_BOUNDS;
        else                                   cause_o = CAUSE_NONE;
    end
endmodule

// File: rtl/cap_monotonic_unit.sv
module cap_monotonic_unit
    import cmu_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic          in_tag,
    input  logic          in_sealed,
    input  logic [PW-1:0] in_perms,
    input  logic [AW-1:0] in_base,
    input  logic [AW-1:0] in_len,
    input  logic [AW-1:0] in_off,
    input  logic [AW-1:0] in_operand,
    output logic          out_valid,
    output logic          out_tag,
    output logic          out_sealed,
    output logic [PW-1:0] out_perms,
    output logic [AW-1:0] out_base,
    output logic [AW-1:0] out_len,
    output logic [AW-1:0] out_off,
    output logic          out_exc,
    output logic [1:0]    out_cause
);
    cmu_op_e       op;
    cmu_cause_e    cause;
    cmu_state_e    st_q, st_d;
    logic [AW-1:0] nb_base;
    logic          nb_viol;
    logic [AW-1:0] alu_off;

    logic          r_tag, r_sealed;
    logic [PW-1:0] r_perms;
    logic [AW-1:0] r_base, r_len, r_off;

    assign op = cmu_op_e'(in_op);

    cmu_bounds #(.AW(AW)) u_bounds (
        .base_i    (in_base),
        .len_i     (in_len),
        .off_i     (in_off),
        .req_len_i (in_operand),
        .new_base_o(nb_base),
        .viol_o    (nb_viol)
    );

    cmu_offset_alu #(.AW(AW)) u_offset (
        .off_i    (in_off),
        .operand_i(in_operand),
        .advance_i(op == OP_ADVOFF),
        .off_o    (alu_off)
    );

    cmu_fault_sel u_fault (
        .tag_i        (in_tag),
        .sealed_i     (in_sealed),
        .bounds_en_i  (op == OP_NARROW),
        .bounds_viol_i(nb_viol),
        .cause_o      (cause)
    );

    // Result datapath: the source passes through unless the request is clean.
    always_comb begin
        r_tag    = in_tag;
        r_sealed = in_sealed;
        r_perms  = in_perms;
        r_base   = in_base;
        r_len    = in_len;
        r_off    = in_off;
        if (cause == CAUSE_NONE) begin
            unique case (op)
                OP_NARROW: begin
                    r_base = nb_base;
                    r_len  = in_operand;
                    r_off  = '0;
                end
                OP_MASK:   r_perms = in_perms & in_operand[PW-1:0];
                OP_SETOFF: r_off   = alu_off;
                OP_ADVOFF: r_off   = alu_off;
            endcase
        end
    end

    // Controller: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (in_valid) st_d = ST_RESULT;
            ST_RESULT: if (!in_valid) st_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_tag    <= 1'b0;
            out_sealed <= 1'b0;
            out_perms  <= '0;
            out_base   <= '0;
            out_len    <= '0;
            out_off    <= '0;
            out_exc    <= 1'b0;
            out_cause  <= CAUSE_NONE;
        end else if (in_valid) begin
            out_tag    <= r_tag;
            out_sealed <= r_sealed;
            out_perms  <= r_perms;
            out_base   <= r_base;
            out_len    <= r_len;
            out_off    <= r_off;
            out_exc    <= (cause != CAUSE_NONE);
            out_cause  <= cause;
        end
    end

    assign out_valid = (st_q == ST_RESULT);
endmodule

// File: rtl/cap_monotonic_unit_chk.sv
module cap_monotonic_unit_chk #(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic          in_tag,
    input logic          in_sealed,
    input logic [PW-1:0] in_perms,
    input logic [AW-1:0] in_base,
    input logic [AW-1:0] in_len,
    input logic [AW-1:0] in_off,
    input logic          out_valid,
    input logic          out_tag,
    input logic          out_sealed,
    input logic [PW-1:0] out_perms,
    input logic [AW-1:0] out_base,
    input logic [AW-1:0] out_len,
    input logic [AW-1:0] out_off,
    input logic          out_exc,
    input logic [1:0]    out_cause
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_BOUNDS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_exc && $past(in_op) == 2'b00) |->
        ((out_base >= $past(in_base)) &&
         ({1'b0, out_base} + {1'b0, out_len} <= {1'b0, $past(in_base)} + {1'b0, $past(in_len)}))); // R3
    AST_PERMS_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_perms & ~$past(in_perms)) == '0)); // R4
    AST_UNTAGGED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_tag)) |-> (!out_tag && out_exc && out_cause == 2'b01)); // R7
    AST_SEALED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_tag) && $past(in_sealed)) |-> (out_exc && out_cause == 2'b10)); // R8
    AST_FAULT_KEEPS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exc) |->
        (out_base == $past(in_base) && out_len == $past(in_len) && out_off == $past(in_off)
         && out_tag == $past(in_tag) && out_sealed == $past(in_sealed))); // R9
    AST_CLEAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_exc) |-> (out_tag && !out_sealed && out_cause == 2'b00)); // R10
endmodule

bind cap_monotonic_unit cap_monotonic_unit_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_tag(in_tag),
    .in_sealed(in_sealed), .in_perms(in_perms), .in_base(in_base), .in_len(in_len),
    .in_off(in_off), .out_valid(out_valid), .out_tag(out_tag), .out_sealed(out_sealed),
    .out_perms(out_perms), .out_base(out_base), .out_len(out_len), .out_off(out_off),
    .out_exc(out_exc), .out_cause(out_cause)
);

// File: tb/cap_monotonic_unit_tb_top.sv
`timescale 1ns/1ps
module cap_monotonic_unit_tb_top;
    localparam int AW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_op = '0;
    logic          in_tag = 1'b0, in_sealed = 1'b0;
    logic [PW-1:0] in_perms = '0;
    logic [AW-1:0] in_base = '0, in_len = '0, in_off = '0, in_operand = '0;
    logic          out_valid, out_tag, out_sealed, out_exc;
    logic [PW-1:0] out_perms;
    logic [AW-1:0] out_base, out_len, out_off;
    logic [1:0]    out_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cap_monotonic_unit #(.AW(AW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_tag(in_tag),
        .in_sealed(in_sealed), .in_perms(in_perms), .in_base(in_base), .in_len(in_len),
        .in_off(in_off), .in_operand(in_operand), .out_valid(out_valid), .out_tag(out_tag),
        .out_sealed(out_sealed), .out_perms(out_perms), .out_base(out_base),
        .out_len(out_len), .out_off(out_off), .out_exc(out_exc), .out_cause(out_cause)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one request, then sample its registered result at the next falling edge.
    task automatic apply(input logic [1:0] op, input logic tag, input logic sealed,
                         input logic [PW-1:0] perms, input logic [AW-1:0] base,
                         input logic [AW-1:0] len, input logic [AW-1:0] off,
                         input logic [AW-1:0] operand);
        @(negedge clk);
        in_op = op; in_tag = tag; in_sealed = sealed; in_perms = perms;
        in_base = base; in_len = len; in_off = off; in_operand = operand;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_cap(input string req, input logic tag, input logic sealed,
                              input logic [PW-1:0] perms, input logic [AW-1:0] base,
                              input logic [AW-1:0] len, input logic [AW-1:0] off,
                              input logic exc, input logic [1:0] cause);
        chk(req, "valid", out_valid, 1'b1);
        chk(req, "tag", out_tag, tag);
        chk(req, "sealed", out_sealed, sealed);
        chk(req, "perms", out_perms, perms);
        chk(req, "base", out_base, base);
        chk(req, "len", out_len, len);
        chk(req, "off", out_off, off);
        chk(req, "exc", out_exc, exc);
        chk(req, "cause", out_cause, cause);
    endtask

    task automatic t_reset;
        chk("R1", "reset valid", out_valid, 1'b0);
        chk("R1", "reset exc", out_exc, 1'b0);
        chk("R1", "reset tag", out_tag, 1'b0);
    endtask

    task automatic t_handshake;
        apply(2'b10, 1'b1, 1'b0, 16'hFFFF, 32'h100, 32'h10, 32'h0, 32'h4);
        chk("R1", "valid after request", out_valid, 1'b1);
        @(negedge clk);
        chk("R1", "valid drops", out_valid, 1'b0);
    endtask

    task automatic t_narrow_ok;
        apply(2'b00, 1'b1, 1'b0, 16'h00FF, 32'h1000, 32'h100, 32'h20, 32'h40);
        expect_cap("R2", 1'b1, 1'b0, 16'h00FF, 32'h1020, 32'h40, 32'h0, 1'b0, 2'b00);
        chk("R10", "clean cause", out_cause, 2'b00);
    endtask

    task automatic t_narrow_edges;
        apply(2'b00, 1'b1, 1'b0, 16'h0003, 32'h1000, 32'h100, 32'h20, 32'hE0);
        expect_cap("R3", 1'b1, 1'b0, 16'h0003, 32'h1020, 32'hE0, 32'h0, 1'b0, 2'b00);
        apply(2'b00, 1'b1, 1'b0, 16'h0003, 32'h1000, 32'h100, 32'h20, 32'hE1);
        expect_cap("R3", 1'b1, 1'b0, 16'h0003, 32'h1000, 32'h100, 32'h20, 1'b1, 2'b11);
        apply(2'b00, 1'b1, 1'b0, 16'h0003, 32'h1000, 32'h100, 32'h200, 32'h0);
        expect_cap("R3", 1'b1, 1'b0, 16'h0003, 32'h1000, 32'h100, 32'h200, 1'b1, 2'b11);
        apply(2'b00, 1'b1, 1'b0, 16'h0003, 32'hFFFF_FF00, 32'h100, 32'h0, 32'h100);
        expect_cap("R3", 1'b1, 1'b0, 16'h0003, 32'hFFFF_FF00, 32'h100, 32'h0, 1'b0, 2'b00);
    endtask

    task automatic t_mask;
        apply(2'b01, 1'b1, 1'b0, 16'hF0F0, 32'h2000, 32'h80, 32'h8, 32'hABCD_FF00);
        expect_cap("R4", 1'b1, 1'b0, 16'hF000, 32'h2000, 32'h80, 32'h8, 1'b0, 2'b00);
    endtask

    task automatic t_setoff;
        apply(2'b10, 1'b1, 1'b0, 16'h0001, 32'h2000, 32'h80, 32'h8, 32'h5000);
        expect_cap("R5", 1'b1, 1'b0, 16'h0001, 32'h2000, 32'h80, 32'h5000, 1'b0, 2'b00);
    endtask

    task automatic t_advoff;
        apply(2'b11, 1'b1, 1'b0, 16'h0001, 32'h2000, 32'h80, 32'hFFFF_FFF0, 32'h20);
        expect_cap("R6", 1'b1, 1'b0, 16'h0001, 32'h2000, 32'h80, 32'h10, 1'b0, 2'b00);
    endtask

    task automatic t_untagged;
        apply(2'b00, 1'b0, 1'b1, 16'h00AA, 32'h3000, 32'h10, 32'h40, 32'h100);
        expect_cap("R7", 1'b0, 1'b1, 16'h00AA, 32'h3000, 32'h10, 32'h40, 1'b1, 2'b01);
        apply(2'b01, 1'b0, 1'b0, 16'h00AA, 32'h3000, 32'h10, 32'h4, 32'h0);
        expect_cap("R9", 1'b0, 1'b0, 16'h00AA, 32'h3000, 32'h10, 32'h4, 1'b1, 2'b01);
    endtask

    task automatic t_sealed;
        apply(2'b00, 1'b1, 1'b1, 16'h0F0F, 32'h4000, 32'h10, 32'h40, 32'h100);
        expect_cap("R8", 1'b1, 1'b1, 16'h0F0F, 32'h4000, 32'h10, 32'h40, 1'b1, 2'b10);
        apply(2'b11, 1'b1, 1'b1, 16'h0F0F, 32'h4000, 32'h10, 32'h4, 32'h1);
        expect_cap("R9", 1'b1, 1'b1, 16'h0F0F, 32'h4000, 32'h10, 32'h4, 1'b1, 2'b10);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_handshake();
        t_narrow_ok();
        t_narrow_edges();
        t_mask();
        t_setoff();
        t_advoff();
        t_untagged();
        t_sealed();
        @(negedge clk);
        chk("R1", "idle after stream", out_valid, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule